// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. It stores words of parameterised width, 36 bits by default, in a RAM of 2^AW entries. Each side keeps its own binary pointer and sends a Gray-coded copy of it across to the other side through two flip-flops. Each side builds its word count from its own pointer and the pointer it has received.

Two offsets set where the level flags switch. One offset is for the nearly-empty flag and one is for the nearly-full flag. Both are loaded from the write data bus and read back on the read data bus while a load-select input is high. Access always starts at the nearly-empty offset, goes next to the nearly-full offset, and then wraps. The nearly-full flag is active low and changes only on write-clock edges.

A mode input is captured when master reset falls. Low selects standard mode, in which a read strobe fetches the next word. High selects fall-through mode, in which the oldest word appears at the output by itself. In fall-through mode the output register counts as one extra word of storage.

Top module: `dcfifo_pflag`

## Requirements
- R1: While and after master reset, and before any access: `empty_o`=1, `full_o`=0, `afull_no`=1 and `aempty_no`=0. Reading back either offset returns DEF_OFF.
- R2: In standard mode, each read accepted while `empty_o`=0 puts the oldest stored word on `dout_o` one read-clock edge later. Words come out in the order they were written. Each pointer changes by at most one Gray bit per edge.
- R3: `full_o` rises on the write edge that makes the RAM hold 2^AW words. A write strobe while `full_o`=1 stores nothing, and that word never appears at the output.
- R4: A read strobe while `empty_o`=1 consumes nothing and leaves `dout_o` unchanged.
- R5: `afull_no` goes low on the write edge that brings the count to D−m or above. Here m is the nearly-full offset, and D is 2^AW in standard mode or 2^AW+1 in fall-through mode.
- R6: Once reads bring the count down to D−(m+1) or below, `afull_no` returns high within four write-clock edges of the last read edge.
- R7: `aempty_no` is low while the count, as seen in the read domain, is n or less, where n is the nearly-empty offset. It is updated on read-clock edges.
- R8: While `ld_i`=1 and `wen_i`=1, each write edge stores `din_i[AW:0]` into an offset register. The registers are written in turn: nearly-empty (select 0), then nearly-full (select 1), then back to nearly-empty. Nothing enters the FIFO during these edges.
- R9: While `ld_i`=1 and `ren_i`=1, each read edge shows one offset on `dout_o`, zero-extended, in the same order with wrap. No word is consumed. `dout_o` shows FIFO data again after `ld_i` falls.
- R10: In fall-through mode (`fwft_i`=1 at reset), the oldest word appears on `dout_o` with `empty_o`=0 without any read strobe. A read strobe advances to the next word.
- R11: In fall-through mode, 2^AW+1 words can be held. `full_o` rises when the RAM is full behind a valid output word, and R5 uses D=2^AW+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| fwft_i | input | 1 | Mode select, captured at reset: 1 = fall-through |
| wen_i | input | 1 | Write strobe |
| ld_i | input | 1 | Offset access select |
| din_i | input | W | Write data and offset load value |
| full_o | output | 1 | RAM full |
| afull_no | output | 1 | Nearly-full flag, active low |
| ren_i | input | 1 | Read strobe |
| dout_o | output | W | Read data or offset readback |
| empty_o | output | 1 | No word available |
| aempty_no | output | 1 | Nearly-empty flag, active low |

## Verification
The bench builds the block with AW=3, giving an 8-word RAM, and DEF_OFF=2. With a RAM this small, the tests can reach full, the nearly-full boundary on both sides of D−m, and the nine-word fall-through capacity with only a few dozen writes. The offsets are reloaded at run time to 1 and 3, so both flag thresholds sit inside that small range. The reload uses three load edges, so the test also covers the wrap of the select order. The read clock runs at a different period from the write clock, so every flag that depends on the other side is seen only after the pointer has crossed.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} off_sel_e;
endpackage

// File: rtl/dcfifo_gray_sync.sv
module dcfifo_gray_sync #(
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int W  = 36,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DEF_OFF = 127,
  localparam int PW     = AW + 2,
  localparam int OFW    = AW + 1
) (
  input  logic           wclk_i,
  input  logic           rst_ni,
  input  logic           fwft_i,
  input  logic           wen_i,
  input  logic           ld_i,
  input  logic [OFW-1:0] ld_data_i,
  input  logic [PW-1:0]  rram_bin_i,
  input  logic [PW-1:0]  rusr_bin_i,
  output logic           we_o,
  output logic [AW-1:0]  waddr_o,
  output logic [PW-1:0]  wgray_o,
  output logic           full_o,
  output logic           afull_no,
  output logic [OFW-1:0] ae_off_o,
  output logic [OFW-1:0] af_off_o
);
  localparam int DEPTH = 1 << AW;

  logic           fwft_q, full_q, afull_nq;
  logic [PW-1:0]  wptr_q, wgray_q, wptr_nxt, ram_cnt, usr_cnt, dmax, af_lim;
  logic [OFW-1:0] ae_off_q, af_off_q;
  off_sel_e       wsel_q;
  logic           push;

  // mode sampled when master reset falls
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) fwft_q <= fwft_i;
  end

  assign push     = wen_i & ~ld_i & ~full_q;
  assign wptr_nxt = wptr_q + PW'(push);
  assign ram_cnt  = wptr_nxt - rram_bin_i;
  assign usr_cnt  = wptr_nxt - rusr_bin_i;
  assign dmax     = fwft_q ? PW'(DEPTH + 1) : PW'(DEPTH);
  assign af_lim   = dmax - PW'(af_off_q);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      wgray_q  <= '0;
      full_q   <= 1'b0;
      afull_nq <= 1'b1;
    end else begin
      wptr_q   <= wptr_nxt;
      wgray_q  <= wptr_nxt ^ (wptr_nxt >> 1);
      full_q   <= ram_cnt >= PW'(DEPTH);
      afull_nq <= ~(usr_cnt >= af_lim);
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_off_q <= OFW'(DEF_OFF);
      af_off_q <= OFW'(DEF_OFF);
      wsel_q   <= SEL_AE;
    end else if (ld_i && wen_i) begin
      if (wsel_q == SEL_AE) ae_off_q <= ld_data_i;
      else                  af_off_q <= ld_data_i;
      wsel_q <= (wsel_q == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  assign we_o     = push;
  assign waddr_o  = wptr_q[AW-1:0];
  assign wgray_o  = wgray_q;
  assign full_o   = full_q;
  assign afull_no = afull_nq;
  assign ae_off_o = ae_off_q;
  assign af_off_o = af_off_q;
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int W    = 36,
  parameter int AW   = 8,
  localparam int PW  = AW + 2,
  localparam int OFW = AW + 1
) (
  input  logic           rclk_i,
  input  logic           rst_ni,
  input  logic           fwft_i,
  input  logic           ren_i,
  input  logic           ld_i,
  input  logic [PW-1:0]  wbin_i,
  input  logic [W-1:0]   rdata_i,
  input  logic [OFW-1:0] ae_off_i,
  input  logic [OFW-1:0] af_off_i,
  output logic [AW-1:0]  raddr_o,
  output logic [PW-1:0]  rram_gray_o,
  output logic [PW-1:0]  rusr_gray_o,
  output logic [W-1:0]   dout_o,
  output logic           empty_o,
  output logic           aempty_no
);
  logic          fwft_q, empty_q, ov_q, aempty_nq, rb_q;
  logic [PW-1:0] rram_q, rusr_q, rram_gray_q, rusr_gray_q;
  logic [PW-1:0] rram_nxt, rusr_nxt, usr_cnt;
  logic [W-1:0]  data_q, off_q;
  off_sel_e      rsel_q;
  logic          rd_ok, ram_avail, ft_load, pop_ram, pop_usr, ov_nxt;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) fwft_q <= fwft_i;
  end

  assign rd_ok     = ren_i & ~ld_i;
  assign ram_avail = (wbin_i != rram_q);
  // fall-through refill: output slot empty or being consumed
  assign ft_load   = ram_avail & ~ld_i & (~ov_q | ren_i);
  assign pop_ram   = fwft_q ? ft_load : (rd_ok & ~empty_q);
  assign pop_usr   = fwft_q ? (rd_ok & ov_q) : (rd_ok & ~empty_q);
  assign ov_nxt    = ft_load | (ov_q & ~rd_ok);
  assign rram_nxt  = rram_q + PW'(pop_ram);
  assign rusr_nxt  = rusr_q + PW'(pop_usr);
  assign usr_cnt   = wbin_i - rusr_nxt;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rram_q      <= '0;
      rusr_q      <= '0;
      rram_gray_q <= '0;
      rusr_gray_q <= '0;
      empty_q     <= 1'b1;
      ov_q        <= 1'b0;
      aempty_nq   <= 1'b0;
      data_q      <= '0;
    end else begin
      rram_q      <= rram_nxt;
      rusr_q      <= rusr_nxt;
      rram_gray_q <= rram_nxt ^ (rram_nxt >> 1);
      rusr_gray_q <= rusr_nxt ^ (rusr_nxt >> 1);
      ov_q        <= fwft_q & ov_nxt;
      empty_q     <= fwft_q ? ~ov_nxt : (wbin_i == rram_nxt);
      aempty_nq   <= ~(usr_cnt <= PW'(ae_off_i));
      if (pop_ram) data_q <= rdata_i;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      rsel_q <= SEL_AE;
      rb_q   <= 1'b0;
    end else begin
      rb_q <= ld_i & (ren_i | rb_q);
      if (ld_i && ren_i) begin
        off_q  <= (rsel_q == SEL_AE) ? W'(ae_off_i) : W'(af_off_i);
        rsel_q <= (rsel_q == SEL_AE) ? SEL_AF : SEL_AE;
      end
    end
  end

  assign raddr_o     = rram_q[AW-1:0];
  assign rram_gray_o = rram_gray_q;
  assign rusr_gray_o = rusr_gray_q;
  assign dout_o      = rb_q ? off_q : data_q;
  assign empty_o     = empty_q;
  assign aempty_no   = aempty_nq;
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int W       = 36,
  parameter int AW      = 8,
  parameter int DEF_OFF = 127
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         fwft_i,
  input  logic         wen_i,
  input  logic         ld_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic         afull_no,
  input  logic         ren_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         aempty_no
);
  localparam int PW  = AW + 2;
  localparam int OFW = AW + 1;
  localparam int NRP = 2;  // read pointers crossed to write side

  logic           mem_we;
  logic [AW-1:0]  mem_waddr, mem_raddr;
  logic [W-1:0]   mem_rdata;
  logic [PW-1:0]  wgray, wbin_r, rram_gray, rusr_gray;
  logic [OFW-1:0] ae_off, af_off;
  logic [PW-1:0]  r2w_gray [NRP];
  logic [PW-1:0]  r2w_bin  [NRP];

  assign r2w_gray[0] = rram_gray;
  assign r2w_gray[1] = rusr_gray;

  for (genvar g = 0; g < NRP; g++) begin : g_r2w
    dcfifo_gray_sync #(.PW(PW)) u_sync (
      .clk_i  (wclk_i),
      .rst_ni (rst_ni),
      .gray_i (r2w_gray[g]),
      .bin_o  (r2w_bin[g])
    );
  end

  dcfifo_gray_sync #(.PW(PW)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .gray_i (wgray),
    .bin_o  (wbin_r)
  );

  dcfifo_wr_ctl #(.AW(AW), .DEF_OFF(DEF_OFF)) u_wr (
    .wclk_i     (wclk_i),
    .rst_ni     (rst_ni),
    .fwft_i     (fwft_i),
    .wen_i      (wen_i),
    .ld_i       (ld_i),
    .ld_data_i  (din_i[OFW-1:0]),
    .rram_bin_i (r2w_bin[0]),
    .rusr_bin_i (r2w_bin[1]),
    .we_o       (mem_we),
    .waddr_o    (mem_waddr),
    .wgray_o    (wgray),
    .full_o     (full_o),
    .afull_no   (afull_no),
    .ae_off_o   (ae_off),
    .af_off_o   (af_off)
  );

  dcfifo_ram #(.W(W), .AW(AW)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (din_i),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  dcfifo_rd_ctl #(.W(W), .AW(AW)) u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .fwft_i      (fwft_i),
    .ren_i       (ren_i),
    .ld_i        (ld_i),
    .wbin_i      (wbin_r),
    .rdata_i     (mem_rdata),
    .ae_off_i    (ae_off),
    .af_off_i    (af_off),
    .raddr_o     (mem_raddr),
    .rram_gray_o (rram_gray),
    .rusr_gray_o (rusr_gray),
    .dout_o      (dout_o),
    .empty_o     (empty_o),
    .aempty_no   (aempty_no)
  );
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int PW = 10
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen_i,
  input logic          ren_i,
  input logic          ld_i,
  input logic          full_o,
  input logic          empty_o,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rram_gray,
  input logic [PW-1:0] rusr_gray
);
  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && wen_i) |=> $stable(wgray));

  assert_no_underflow_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && ren_i) |=> $stable(rusr_gray));

  assert_ld_blocks_write_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_i |=> $stable(wgray));

  assert_ld_blocks_read_R9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ld_i |=> $stable(rusr_gray));

  assert_wgray_step_R2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray ^ $past(wgray)));

  assert_rram_step_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $onehot0(rram_gray ^ $past(rram_gray)));

  assert_rusr_step_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $onehot0(rusr_gray ^ $past(rusr_gray)));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(PW)) u_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .wen_i     (wen_i),
  .ren_i     (ren_i),
  .ld_i      (ld_i),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .wgray     (wgray),
  .rram_gray (rram_gray),
  .rusr_gray (rusr_gray)
);

// File: tb/sim_dcfifo_pflag.sv
module sim_dcfifo_pflag;
  localparam int W = 36, AW = 3, DEF_OFF = 2;

  logic         wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b1, fwft = 1'b0;
  logic         wen = 1'b0, ren = 1'b0, ld = 1'b0;
  logic [W-1:0] din = '0;
  logic         full, afull_n, empty, aempty_n;
  logic [W-1:0] dout;

  int           total = 0, bad = 0;
  logic [W-1:0] exp_q [$];
  logic [W-1:0] last_dout = '0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_pflag #(.W(W), .AW(AW), .DEF_OFF(DEF_OFF)) u0 (
    .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_ni), .fwft_i (fwft),
    .wen_i (wen), .ld_i (ld), .din_i (din), .full_o (full),
    .afull_no (afull_n), .ren_i (ren), .dout_o (dout),
    .empty_o (empty), .aempty_no (aempty_n)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge wclk);
    fwft = mode; wen = 0; ren = 0; ld = 0;
    rst_ni = 0;
    repeat (4) @(negedge rclk);
    rst_ni = 1;
    repeat (3) @(negedge rclk);
    exp_q.delete();
  endtask

  // driver: pushes the word to the scoreboard when the write is accepted
  task automatic write_word(input logic [W-1:0] d, output bit acc);
    @(negedge wclk);
    acc = !full;
    din = d; wen = 1;
    if (acc) exp_q.push_back(d);
    @(negedge wclk);
    wen = 0;
  endtask

  // monitor, standard mode: word shows one edge after the strobe
  task automatic read_std(input string req);
    logic [W-1:0] e;
    @(negedge rclk);
    if (!empty) begin
      ren = 1;
      @(negedge rclk);
      ren = 0;
      e = exp_q.pop_front();
      check(req, dout, e);
      last_dout = dout;
    end else begin
      check({req, " unexpected empty"}, W'(empty), '0);
    end
  endtask

  // monitor, fall-through mode: word is present before the strobe
  task automatic read_fwft(input string req);
    @(negedge rclk);
    if (!empty) begin
      check(req, dout, exp_q.pop_front());
      ren = 1;
      @(negedge rclk);
      ren = 0;
    end else begin
      check({req, " unexpected empty"}, W'(empty), '0);
    end
  endtask

  task automatic ld_write(input logic [W-1:0] v);
    @(negedge wclk);
    ld = 1; wen = 1; din = v;
    @(negedge wclk);
    ld = 0; wen = 0;
  endtask

  task automatic ld_read(input string req, input logic [W-1:0] exp);
    @(negedge rclk);
    ld = 1; ren = 1;
    @(negedge rclk);
    check(req, dout, exp);
    ld = 0; ren = 0;
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit acc;
    #1;
    // ---------- standard mode ----------
    do_reset(1'b0);
    check("R1 empty", W'(empty), 1);
    check("R1 full", W'(full), 0);
    check("R1 afull_n", W'(afull_n), 1);
    check("R1 aempty_n", W'(aempty_n), 0);
    ld_read("R1 ae default", W'(DEF_OFF));
    ld_read("R1 af default", W'(DEF_OFF));

    // R8: three loads wrap: ae=7 then af=3 then ae=1
    ld_write(36'd7); ld_write(36'd3); ld_write(36'd1);
    repeat (4) @(negedge rclk);
    check("R8 loads not queued", W'(empty), 1);
    ld_read("R9 ae", 36'd1);
    ld_read("R9 af", 36'd3);
    ld_read("R9 wrap ae", 36'd1);
    ld_read("R9 wrap af", 36'd3);

    // fill: D=8, m=3 -> afull low at count>=5; n=1 -> aempty high at count>=2
    for (int k = 1; k <= 8; k++) begin
      write_word(36'hA00 + k, acc);
      check("R5 afull_n level", W'(afull_n), (k < 5) ? 1 : 0);
      if (k <= 2) begin
        repeat (6) @(negedge rclk);
        check("R7 aempty_n level", W'(aempty_n), (k >= 2) ? 1 : 0);
      end
    end
    check("R3 full at depth", W'(full), 1);
    write_word(36'hBAD, acc);
    check("R3 write while full refused", W'(acc), 0);
    check("R3 still full", W'(full), 1);

    repeat (4) @(negedge rclk);
    ld_read("R9 readback during data", 36'd1);

    read_std("R2 order"); read_std("R2 order"); read_std("R2 order");
    repeat (6) @(negedge wclk);
    check("R5 afull_n held at D-m", W'(afull_n), 0);
    read_std("R2 order");
    repeat (5) @(negedge wclk);
    check("R6 afull_n released", W'(afull_n), 1);
    check("R3 full released", W'(full), 0);
    for (int k = 0; k < 4; k++) read_std("R2 order");
    repeat (3) @(negedge rclk);
    check("R2 drained", W'(empty), 1);

    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
    check("R4 dout unchanged", dout, last_dout);
    check("R4 still empty", W'(empty), 1);

    // ---------- fall-through mode: D=9, m=2 ----------
    do_reset(1'b1);
    ld_read("R1 ae restored", W'(DEF_OFF));
    for (int k = 1; k <= 9; k++) begin
      write_word(36'hC00 + k, acc);
      check("R11 write accepted", W'(acc), 1);
      check("R11 afull_n level", W'(afull_n), (k < 7) ? 1 : 0);
      if (k == 1) begin
        repeat (5) @(negedge rclk);
        check("R10 falls through", dout, 36'hC01);
        check("R10 not empty", W'(empty), 0);
      end
      repeat (4) @(negedge wclk);
    end
    check("R11 full at depth+1", W'(full), 1);
    write_word(36'hBAD, acc);
    check("R11 tenth write refused", W'(acc), 0);
    for (int k = 0; k < 9; k++) read_fwft("R10 order");
    repeat (3) @(negedge rclk);
    check("R10 drained", W'(empty), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule